// File: doc/BRIEF.md
# Strobed Parallel Bus Slave

This block is a target on an eight-bit parallel bus driven by an external host. The host starts every transfer by pulling one of two strobes low. The address strobe opens an address cycle. The data strobe opens a data cycle. A direction line chooses between a host write (low) and a host read (high). The block answers each cycle by raising a wait handshake. The host then holds the strobe until it sees that handshake, and releases it afterwards.

The block holds an eight-bit address register and sixteen eight-bit storage registers. An address cycle writes or reads the address register itself. A data cycle writes or reads the storage register picked by the low four bits of the address register. All control inputs arrive asynchronously and pass through two-stage synchronizers. On reads, the block drives its output bus and raises an output-enable flag so that an external tri-state buffer can be steered.

Top module: `pbus_slave`

## Requirements
- R1: After reset, `wait_o` and `bus_oe` are 0, `bus_dout` is 0x00, the address register is 0x00, and all sixteen storage registers are 0x00.
- R2: A cycle with `addr_stb_n` low and `wr_n` low loads the value on `bus_din` into the address register.
- R3: A cycle with `addr_stb_n` low and `wr_n` high returns the address register on `bus_dout` while `bus_oe` is 1.
- R4: A cycle with `data_stb_n` low and `wr_n` low writes `bus_din` into the storage register selected by address bits [3:0]. No other storage register changes.
- R5: A cycle with `data_stb_n` low and `wr_n` high returns the selected storage register on `bus_dout` while `bus_oe` is 1. Address bits [7:4] play no part in the selection.
- R6: `wait_o` rises only after exactly one strobe has been seen low. It stays high for as long as that strobe stays low. It falls within four clock cycles after the strobe returns high.
- R7: `bus_oe` is 1 only during a read cycle that has been acknowledged. It is never 1 during a write cycle, and it falls together with `wait_o`.
- R8: If both strobes are seen low in the same cycle, the transfer is dropped. `wait_o` stays 0, neither the address register nor any storage register changes, and no new cycle starts until both strobes are high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_stb_n | input | 1 | Address-cycle strobe, active low, asynchronous |
| data_stb_n | input | 1 | Data-cycle strobe, active low, asynchronous |
| wr_n | input | 1 | Direction: 0 host writes, 1 host reads |
| bus_din | input | 8 | Bus value seen from the host |
| wait_o | output | 1 | Cycle acknowledge handshake |
| bus_oe | output | 1 | Enable for the external bus driver during reads |
| bus_dout | output | 8 | Read data toward the host |

## Verification
Address-cycle detection and data-cycle detection can fire in the same synchronized cycle. This happens when the host lowers both strobes together. Both are switched in the same bench time step, so both synchronizer chains settle on the same clock edge. The outcome is judged at the ports in two ways. First, `wait_o` and `bus_oe` must stay low through a long hold of both strobes. Second, after release, an address read and a data read must show that neither the address register nor the selected storage register took the byte that was on the bus.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_BAD  = 2'd2
  } pbus_state_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = chain[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else        chain[g] <= src;
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DEPTH-1:0][DW-1:0] mem;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic sel;
    assign sel = we && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= '0;
      else if (sel) mem[i] <= wdata;
    end
  end

  assign rdata = mem[addr];

  AST_RF_ONLY_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem)); // R4
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           astb_s,
  input  logic           dstb_s,
  input  logic           rd_s,
  input  logic [DW-1:0]  din,
  input  logic [DW-1:0]  rf_rdata,
  output logic [DW-1:0]  addr_q,
  output logic           rf_we,
  output logic           wait_q,
  output logic           oe_q,
  output logic [DW-1:0]  dout_q
);
  pbus_state_e   state_q, state_d;
  logic [DW-1:0] addr_d, dout_d;
  logic          wait_d, oe_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    dout_d  = dout_q;
    wait_d  = wait_q;
    oe_d    = oe_q;
    rf_we   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (astb_s && dstb_s) begin
          state_d = ST_BAD;
        end else if (astb_s || dstb_s) begin
          state_d = ST_ACK;
          wait_d  = 1'b1;
          if (rd_s) begin
            oe_d   = 1'b1;
            dout_d = astb_s ? addr_q : rf_rdata;
          end else if (astb_s) begin
            addr_d = din;
          end else begin
            rf_we  = 1'b1;
          end
        end
      end
      ST_ACK: begin
        if (!astb_s && !dstb_s) begin
          state_d = ST_IDLE;
          wait_d  = 1'b0;
          oe_d    = 1'b0;
        end
      end
      ST_BAD: begin
        if (!astb_s && !dstb_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dout_q  <= '0;
      wait_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      wait_q  <= wait_d;
      oe_q    <= oe_d;
    end
  end

  AST_WAIT_ONE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> $past(astb_s ^ dstb_s)); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && (astb_s || dstb_s)) |=> wait_q); // R6
  AST_WAIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !astb_s && !dstb_s) |=> (!wait_q && !oe_q)); // R6
  AST_BOTH_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && astb_s && dstb_s) |=> !wait_q); // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(rd_s)); // R7
  AST_OE_WITH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> wait_q); // R7
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int SYNC_STGS = 2,
  localparam int RAW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_stb_n,
  input  logic          data_stb_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_din,
  output logic          wait_o,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout
);
  logic [2:0]    ctl_s;
  logic [DW-1:0] addr_q, rf_rdata;
  logic          rf_we;

  pbus_sync #(.WIDTH(3), .STAGES(SYNC_STGS), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({wr_n, data_stb_n, addr_stb_n}),
    .q     (ctl_s)
  );

  pbus_ctrl #(.DW(DW), .RAW(RAW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .astb_s   (!ctl_s[0]),
    .dstb_s   (!ctl_s[1]),
    .rd_s     (ctl_s[2]),
    .din      (bus_din),
    .rf_rdata (rf_rdata),
    .addr_q   (addr_q),
    .rf_we    (rf_we),
    .wait_q   (wait_o),
    .oe_q     (bus_oe),
    .dout_q   (bus_dout)
  );

  pbus_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .addr  (addr_q[RAW-1:0]),
    .wdata (bus_din),
    .rdata (rf_rdata)
  );
endmodule

// File: tb/pbus_slave_tb.sv
module pbus_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_stb_n = 1'b1;
  logic       data_stb_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic       wait_o, bus_oe;
  logic [7:0] bus_dout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [7:0] shadow [16];

  always #5 clk = ~clk;

  pbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
    .wr_n(wr_n), .bus_din(bus_din), .wait_o(wait_o), .bus_oe(bus_oe), .bus_dout(bus_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus transfer; returns the byte seen on bus_dout for reads.
  task automatic xfer(input bit is_addr, input bit is_wr, input logic [7:0] wdat,
                      input string req, output logic [7:0] rdat);
    int n;
    rdat = 8'h00;
    @(negedge clk);
    wr_n = !is_wr;
    bus_din = wdat;
    @(negedge clk);
    if (is_addr) addr_stb_n = 1'b0; else data_stb_n = 1'b0;
    n = 0;
    while (!wait_o && n < 50) begin @(negedge clk); n++; end
    chk(wait_o == 1'b1, {req, " wait raised"}, wait_o, 1);
    chk(bus_oe == !is_wr, {req, " oe level"}, bus_oe, !is_wr);
    rdat = bus_dout;
    @(negedge clk);
    addr_stb_n = 1'b1;
    data_stb_n = 1'b1;
    n = 0;
    while (wait_o && n < 50) begin @(negedge clk); n++; end
    chk(!wait_o && !bus_oe, {req, " wait/oe released"}, {wait_o, bus_oe}, 0);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk(wait_o == 0 && bus_oe == 0 && bus_dout == 0, "R1 idle outputs", {wait_o, bus_oe, bus_dout}, 0);
    xfer(1, 0, 8'h0, "R1", r); // reads address register
    chk(r == 8'h00, "R1 address reset", r, 0);
    xfer(0, 0, 8'h0, "R1", r);
    chk(r == 8'h00, "R1 storage reset", r, 0);
  endtask

  task automatic t_addr();
    logic [7:0] r;
    xfer(1, 1, 8'h5A, "R2", r);
    xfer(1, 0, 8'h00, "R3", r);
    chk(r == 8'h5A, "R2 R3 address readback", r, 8'h5A);
    xfer(1, 1, 8'hC3, "R2", r);
    xfer(1, 0, 8'h00, "R3", r);
    chk(r == 8'hC3, "R3 second address readback", r, 8'hC3);
  endtask

  task automatic t_data();
    logic [7:0] r;
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 8'(i * 17 + 3);
      xfer(1, 1, 8'(i), "R2", r);
      xfer(0, 1, shadow[i], "R4", r);
    end
    for (int i = 15; i >= 0; i--) begin
      xfer(1, 1, 8'(i), "R2", r);
      xfer(0, 0, 8'h00, "R5", r);
      chk(r == shadow[i], "R4 R5 storage readback", r, shadow[i]);
    end
  endtask

  task automatic t_alias();
    logic [7:0] r;
    xfer(1, 1, 8'h37, "R5", r);
    xfer(0, 0, 8'h00, "R5", r);
    chk(r == shadow[7], "R5 upper address bits ignored", r, shadow[7]);
    xfer(1, 1, 8'hF7, "R5", r);
    xfer(0, 1, 8'h99, "R4", r);
    shadow[7] = 8'h99;
    xfer(1, 1, 8'h06, "R4", r);
    xfer(0, 0, 8'h00, "R4", r);
    chk(r == shadow[6], "R4 neighbour untouched", r, shadow[6]);
  endtask

  task automatic t_wait_hold();
    int n;
    bit held = 1'b1, oe_seen = 1'b0;
    @(negedge clk);
    wr_n = 1'b0;
    bus_din = 8'h0B;
    @(negedge clk);
    addr_stb_n = 1'b0;
    n = 0;
    while (!wait_o && n < 50) begin @(negedge clk); n++; end
    for (int k = 0; k < 20; k++) begin
      if (!wait_o) held = 1'b0;
      if (bus_oe) oe_seen = 1'b1;
      @(negedge clk);
    end
    chk(held, "R6 wait held during long strobe", held, 1);
    chk(!oe_seen, "R7 oe low on write", oe_seen, 0);
    addr_stb_n = 1'b1;
    n = 0;
    while (wait_o && n < 50) begin @(negedge clk); n++; end
    chk(n <= 4, "R6 wait falls within four cycles", n, 4);
  endtask

  task automatic t_both();
    logic [7:0] r;
    bit seen = 1'b0;
    xfer(1, 1, 8'h02, "R8", r);
    @(negedge clk);
    wr_n = 1'b0;
    bus_din = 8'hFF;
    @(negedge clk);
    addr_stb_n = 1'b0;
    data_stb_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (wait_o || bus_oe) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R8 no wait for dual strobe", seen, 0);
    data_stb_n = 1'b1; // one strobe left low must stay ignored
    for (int k = 0; k < 8; k++) begin
      if (wait_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R8 no restart before full release", seen, 0);
    addr_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(1, 0, 8'h00, "R8", r);
    chk(r == 8'h02, "R8 address unchanged", r, 8'h02);
    xfer(0, 0, 8'h00, "R8", r);
    chk(r == shadow[2], "R8 storage unchanged", r, shadow[2]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_data();
    t_alias();
    t_wait_hold();
    t_both();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule